// File: doc/BRIEF.md
# Tree Reduction Combine Unit

This block sits at one node of a binary-tree collective network. Going up the tree, it takes one word from the local node and one word from each child link that is present. It merges those words with the selected reduction and sends the result toward the parent. Going down the tree, it takes words from the parent and copies each one to the local node and to every present child. A floating-point global sum is built from two passes through the same hardware: an integer maximum first fixes a common exponent scale, then an integer sum adds the aligned mantissas.

The reductions are signed integer maximum, wrapping integer sum, AND, OR and XOR. A broadcast mode forwards words upward without merging them. It is used for one-to-all broadcasts and for messages sent from a segment root down to its leaves. A configuration bit marks the root node. At the root, the merged upward stream is turned around and becomes the downward broadcast, so every contributor receives the single combined result. Every stream uses a valid/ready handshake. A word moves on a cycle in which both valid and ready are high.

Top module: `tree_combine_unit`

## Requirements
- R1: The `opCode` encoding is 001 sum, 010 signed maximum, 011 AND, 100 OR and 101 XOR. In these modes the upward result is the reduction of the local word and the words of all enabled children.
- R2: In a reduction mode, no input is accepted until the local input and every enabled child hold a valid word. All of those inputs are then accepted together, on the same cycle.
- R3: A sum is 64-bit two's complement and wraps on overflow. `upOvf` is set when the true sum does not fit in 64 signed bits, or when any enabled child's `childOvf` is high. In the other reduction modes, `upOvf` is the OR of the enabled children's flags.
- R4: Codes 000, 110 and 111 select broadcast. In broadcast, one input is accepted per word, without merging. The local input has priority over child 0, and child 0 has priority over child 1. The word and its overflow flag are forwarded unchanged.
- R5: A child whose `childEn` bit is 0 is never given ready. Its valid, data and flag have no effect on the result.
- R6: At a non-root node, an accepted result appears on the up port on the next cycle. The word and flag are held stable while `upReady` is low.
- R7: At the root (`isRoot`=1), `upValid` and `dnInReady` stay low. Each upward result is sent into the downward stream instead.
- R8: Each downward word is registered once. It is then offered on `dnData`/`dnOvf` to the local node and to every enabled child, and each destination takes it exactly once. A new word is loaded only when every destination has taken the previous word, or takes it on that same cycle.
- R9: After reset, `upValid`, `dnLocalValid` and every `dnChildValid` bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 3 | Operation selection (see R1, R4) |
| isRoot | input | 1 | Marks this node as the tree root |
| childEn | input | NUM_CHILD | Bit g set when child g exists |
| localValid | input | 1 | Local contribution valid |
| localData | input | DATA_W | Local contribution word |
| localReady | output | 1 | Local contribution accepted |
| childValid | input | NUM_CHILD | Child contribution valid, one bit per child |
| childData | input | NUM_CHILD*DATA_W | Child words, child g at bits g*DATA_W upward |
| childOvf | input | NUM_CHILD | Overflow flag carried up from each child |
| childReady | output | NUM_CHILD | Child contribution accepted |
| upValid | output | 1 | Result to parent valid |
| upData | output | DATA_W | Result word to parent |
| upOvf | output | 1 | Overflow flag to parent |
| upReady | input | 1 | Parent accepts result |
| dnInValid | input | 1 | Word from parent valid |
| dnInData | input | DATA_W | Word from parent |
| dnInOvf | input | 1 | Overflow flag from parent |
| dnInReady | output | 1 | Word from parent accepted |
| dnLocalValid | output | 1 | Downward word pending for the local node |
| dnLocalReady | input | 1 | Local node takes the downward word |
| dnChildValid | output | NUM_CHILD | Downward word pending for each child |
| dnChildReady | input | NUM_CHILD | Child takes the downward word |
| dnData | output | DATA_W | Downward word, shared by all destinations |
| dnOvf | output | 1 | Downward overflow flag |

## Verification
The assertions cover the handshake rules on every cycle:
- a reduction never accepts a partial set of inputs;
- broadcast accepts at most one input per cycle;
- a disabled child never sees ready;
- held up and down words stay stable under back-pressure;
- the root keeps its parent-side handshakes quiet.

The arithmetic can only be shown by the bench's scenarios. These cover wrapping sums with overflow, signed maximum across the sign boundary, bitwise results with disabled children supplying identity values, the order in which broadcast inputs are chosen, and the downward fork delivering each word once to every destination under independent random stalls.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [2:0] {
    OP_BCAST = 3'b000,
    OP_ADD   = 3'b001,
    OP_MAX   = 3'b010,
    OP_AND   = 3'b011,
    OP_OR    = 3'b100,
    OP_XOR   = 3'b101
  } trc_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic upLoad;    // capture a new upward result
    logic dnLoad;    // capture a new downward word
    logic dnFromUp;  // downward word comes from the upward register
    logic selBcast;  // upward result is the selected input, no merging
  } trc_strobe_t;

  function automatic logic opCombines(logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd5);
  endfunction

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int NUM_IN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic              isRoot,
  input  logic [NUM_IN-1:0] inEn,
  input  logic [NUM_IN-1:0] inValid,
  output logic [NUM_IN-1:0] inReady,
  output logic [NUM_IN-1:0] inSel,
  input  logic              upReady,
  output logic              upValid,
  input  logic              dnInValid,
  output logic              dnInReady,
  input  logic [NUM_IN-1:0] dnRdy,
  output logic [NUM_IN-1:0] dnValid,
  output trc_strobe_t       strobe
);

  logic              upValidQ;
  logic [NUM_IN-1:0] dnPendQ;
  logic              combineOp;
  logic              allValid;
  logic              dnSpace;
  logic              upSink;
  logic              upSpace;
  logic              srcValid;
  logic [NUM_IN-1:0] cand;
  logic [NUM_IN-1:0] pick;

  assign combineOp = opCombines(opCode);
  assign cand      = inValid & inEn;
  assign allValid  = &(inValid | ~inEn);

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    pick = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  // downward register is free when every pending destination leaves now
  assign dnSpace  = ((dnPendQ & ~dnRdy) == '0);
  assign upSink   = isRoot ? dnSpace : upReady;
  assign upSpace  = !upValidQ || upSink;
  assign srcValid = isRoot ? upValidQ : dnInValid;

  always_comb begin
    if (combineOp) begin
      inReady = (allValid && upSpace) ? inEn : '0;
    end else begin
      inReady = upSpace ? pick : '0;
    end
  end

  assign inSel            = pick;
  assign strobe.upLoad    = |(inReady & inValid);
  assign strobe.dnLoad    = srcValid && dnSpace;
  assign strobe.dnFromUp  = isRoot;
  assign strobe.selBcast  = !combineOp;

  assign upValid   = upValidQ && !isRoot;
  assign dnInReady = !isRoot && dnSpace;
  assign dnValid   = dnPendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upValidQ <= 1'b0;
      dnPendQ  <= '0;
    end else begin
      if (strobe.upLoad) begin
        upValidQ <= 1'b1;
      end else if (upSink) begin
        upValidQ <= 1'b0;
      end
      if (strobe.dnLoad) begin
        dnPendQ <= inEn;
      end else begin
        dnPendQ <= dnPendQ & ~dnRdy;
      end
    end
  end

endmodule

// File: rtl/trc_dpath.sv
module trc_dpath
  import trc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NUM_IN = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2:0]               opCode,
  input  logic [NUM_IN-1:0]        inEn,
  input  logic [NUM_IN*DATA_W-1:0] inData,
  input  logic [NUM_IN-1:0]        inOvf,
  input  logic [NUM_IN-1:0]        inSel,
  input  trc_strobe_t              strobe,
  input  logic [DATA_W-1:0]        dnInData,
  input  logic                     dnInOvf,
  output logic [DATA_W-1:0]        upData,
  output logic                     upOvf,
  output logic [DATA_W-1:0]        dnData,
  output logic                     dnOvf
);

  localparam int SUM_W = DATA_W + $clog2(NUM_IN);

  logic [DATA_W-1:0] ident;
  logic [DATA_W-1:0] opnd [NUM_IN];
  logic [DATA_W-1:0] acc;
  logic [SUM_W-1:0]  wide;
  logic              sumOvf;
  logic              flagOr;
  logic [DATA_W-1:0] selData;
  logic              selOvf;
  logic [DATA_W-1:0] resData;
  logic              resOvf;
  logic [DATA_W-1:0] upDataQ;
  logic              upOvfQ;
  logic [DATA_W-1:0] dnDataQ;
  logic              dnOvfQ;

  // value that leaves the reduction unchanged, used for absent children
  always_comb begin
    case (opCode)
      OP_AND:  ident = '1;
      OP_MAX:  ident = {1'b1, {(DATA_W-1){1'b0}}};
      default: ident = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_opnd
    assign opnd[g] = inEn[g] ? inData[g*DATA_W +: DATA_W] : ident;
  end

  always_comb begin
    acc  = opnd[0];
    wide = {{(SUM_W-DATA_W){opnd[0][DATA_W-1]}}, opnd[0]};
    for (int i = 1; i < NUM_IN; i++) begin
      wide = wide + {{(SUM_W-DATA_W){opnd[i][DATA_W-1]}}, opnd[i]};
      case (opCode)
        OP_MAX: if ($signed(opnd[i]) > $signed(acc)) acc = opnd[i];
        OP_AND: acc = acc & opnd[i];
        OP_OR:  acc = acc | opnd[i];
        OP_XOR: acc = acc ^ opnd[i];
        default: acc = acc;
      endcase
    end
  end

  assign sumOvf = (wide != {{(SUM_W-DATA_W){wide[DATA_W-1]}}, wide[DATA_W-1:0]});
  assign flagOr = |(inOvf & inEn);

  always_comb begin
    selData = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (inSel[i]) selData = selData | inData[i*DATA_W +: DATA_W];
    end
  end
  assign selOvf = |(inSel & inOvf);

  always_comb begin
    if (strobe.selBcast) begin
      resData = selData;
      resOvf  = selOvf;
    end else if (opCode == OP_ADD) begin
      resData = wide[DATA_W-1:0];
      resOvf  = flagOr || sumOvf;
    end else begin
      resData = acc;
      resOvf  = flagOr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upDataQ <= '0;
      upOvfQ  <= 1'b0;
      dnDataQ <= '0;
      dnOvfQ  <= 1'b0;
    end else begin
      if (strobe.upLoad) begin
        upDataQ <= resData;
        upOvfQ  <= resOvf;
      end
      if (strobe.dnLoad) begin
        dnDataQ <= strobe.dnFromUp ? upDataQ : dnInData;
        dnOvfQ  <= strobe.dnFromUp ? upOvfQ  : dnInOvf;
      end
    end
  end

  assign upData = upDataQ;
  assign upOvf  = upOvfQ;
  assign dnData = dnDataQ;
  assign dnOvf  = dnOvfQ;

endmodule

// File: rtl/tree_combine_unit.sv
module tree_combine_unit
  import trc_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NUM_CHILD = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [2:0]                  opCode,
  input  logic                        isRoot,
  input  logic [NUM_CHILD-1:0]        childEn,
  input  logic                        localValid,
  input  logic [DATA_W-1:0]           localData,
  output logic                        localReady,
  input  logic [NUM_CHILD-1:0]        childValid,
  input  logic [NUM_CHILD*DATA_W-1:0] childData,
  input  logic [NUM_CHILD-1:0]        childOvf,
  output logic [NUM_CHILD-1:0]        childReady,
  output logic                        upValid,
  output logic [DATA_W-1:0]           upData,
  output logic                        upOvf,
  input  logic                        upReady,
  input  logic                        dnInValid,
  input  logic [DATA_W-1:0]           dnInData,
  input  logic                        dnInOvf,
  output logic                        dnInReady,
  output logic                        dnLocalValid,
  input  logic                        dnLocalReady,
  output logic [NUM_CHILD-1:0]        dnChildValid,
  input  logic [NUM_CHILD-1:0]        dnChildReady,
  output logic [DATA_W-1:0]           dnData,
  output logic                        dnOvf
);

  localparam int NUM_IN = NUM_CHILD + 1;

  logic [NUM_IN-1:0] inEn;
  logic [NUM_IN-1:0] inValid;
  logic [NUM_IN-1:0] inReady;
  logic [NUM_IN-1:0] inSel;
  logic [NUM_IN-1:0] inOvf;
  logic [NUM_IN-1:0] dnRdy;
  logic [NUM_IN-1:0] dnValid;
  trc_strobe_t       strobe;

  // slot 0 is the local node, slot g+1 is child g
  assign inEn    = {childEn, 1'b1};
  assign inValid = {childValid, localValid};
  assign inOvf   = {childOvf, 1'b0};
  assign dnRdy   = {dnChildReady, dnLocalReady};

  assign localReady   = inReady[0];
  assign childReady   = inReady[NUM_IN-1:1];
  assign dnLocalValid = dnValid[0];
  assign dnChildValid = dnValid[NUM_IN-1:1];

  trc_ctrl #(.NUM_IN(NUM_IN)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .opCode    (opCode),
    .isRoot    (isRoot),
    .inEn      (inEn),
    .inValid   (inValid),
    .inReady   (inReady),
    .inSel     (inSel),
    .upReady   (upReady),
    .upValid   (upValid),
    .dnInValid (dnInValid),
    .dnInReady (dnInReady),
    .dnRdy     (dnRdy),
    .dnValid   (dnValid),
    .strobe    (strobe)
  );

  trc_dpath #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .opCode   (opCode),
    .inEn     (inEn),
    .inData   ({childData, localData}),
    .inOvf    (inOvf),
    .inSel    (inSel),
    .strobe   (strobe),
    .dnInData (dnInData),
    .dnInOvf  (dnInOvf),
    .upData   (upData),
    .upOvf    (upOvf),
    .dnData   (dnData),
    .dnOvf    (dnOvf)
  );

endmodule

// File: rtl/tree_combine_chk.sv
module tree_combine_chk #(
  parameter int DATA_W    = 64,
  parameter int NUM_CHILD = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           opCode,
  input logic                 isRoot,
  input logic [NUM_CHILD-1:0] childEn,
  input logic                 localValid,
  input logic                 localReady,
  input logic [NUM_CHILD-1:0] childValid,
  input logic [NUM_CHILD-1:0] childReady,
  input logic                 upValid,
  input logic [DATA_W-1:0]    upData,
  input logic                 upOvf,
  input logic                 upReady,
  input logic                 dnInReady,
  input logic                 dnLocalValid,
  input logic                 dnLocalReady,
  input logic [DATA_W-1:0]    dnData,
  input logic                 dnOvf
);

  // R2
  combine_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((opCode >= 3'd1) && (opCode <= 3'd5) && (localReady || (|childReady)))
      |-> (localValid && ((childValid | ~childEn) == '1)));

  // R4
  bcast_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((opCode >= 3'd1) && (opCode <= 3'd5)) |-> $onehot0({childReady, localReady}));

  // R5
  absent_child_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((childReady & ~childEn) == '0));

  // R6
  up_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !upReady && !isRoot) |=> (upValid && $stable(upData) && $stable(upOvf)));

  // R7
  root_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    isRoot |-> (!upValid && !dnInReady));

  // R8
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnLocalValid && !dnLocalReady) |=> (dnLocalValid && $stable(dnData) && $stable(dnOvf)));

endmodule

bind tree_combine_unit tree_combine_chk #(.DATA_W(DATA_W), .NUM_CHILD(NUM_CHILD)) chk_i (.*);

// File: tb/tree_combine_unit_tb_top.sv
module tree_combine_unit_tb_top;

  localparam int W  = 64;
  localparam int NC = 2;
  localparam int NI = NC + 1;

  typedef struct {
    logic [W-1:0] d;
    logic         o;
    logic [2:0]   op;
  } item_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rstN;
  logic [2:0]          opCode;
  logic                isRoot;
  logic [NC-1:0]       childEn;
  logic [NI-1:0]       tbValid;
  logic [NI-1:0][W-1:0] tbData;
  logic [NI-1:0]       tbOvf;
  logic                localReady;
  logic [NC-1:0]       childReady;
  logic                upValid;
  logic [W-1:0]        upData;
  logic                upOvf;
  logic                upReady;
  logic                dnInValid;
  logic [W-1:0]        dnInData;
  logic                dnInOvf;
  logic                dnInReady;
  logic                dnLocalValid;
  logic                dnLocalReady;
  logic [NC-1:0]       dnChildValid;
  logic [NC-1:0]       dnChildReady;
  logic [W-1:0]        dnData;
  logic                dnOvf;

  tree_combine_unit #(.DATA_W(W), .NUM_CHILD(NC)) dut_i (
    .clk(clk), .rstN(rstN), .opCode(opCode), .isRoot(isRoot), .childEn(childEn),
    .localValid(tbValid[0]), .localData(tbData[0]), .localReady(localReady),
    .childValid(tbValid[NI-1:1]), .childData(tbData[NI-1:1]), .childOvf(tbOvf[NI-1:1]),
    .childReady(childReady),
    .upValid(upValid), .upData(upData), .upOvf(upOvf), .upReady(upReady),
    .dnInValid(dnInValid), .dnInData(dnInData), .dnInOvf(dnInOvf), .dnInReady(dnInReady),
    .dnLocalValid(dnLocalValid), .dnLocalReady(dnLocalReady),
    .dnChildValid(dnChildValid), .dnChildReady(dnChildReady),
    .dnData(dnData), .dnOvf(dnOvf)
  );

  int nChecks = 0;
  int nFails  = 0;
  int ovfSeen = 0;
  int bcastSeen = 0;

  item_t         upQ[$];
  logic          mUpV;
  logic [NI-1:0] mDnPend;
  item_t         mDn;
  logic [NI-1:0] hsVec;
  logic          dnInHs;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W:0] act, input logic [W:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference reduction, written from the requirement text
  function automatic item_t refComb(input logic [2:0] op, input logic [NI-1:0] en,
                                    input logic [NI-1:0][W-1:0] d, input logic [NI-1:0] o);
    item_t r;
    logic signed [W+1:0] s;
    r.d = d[0]; r.o = 1'b0; r.op = op;
    s = $signed({{2{d[0][W-1]}}, d[0]});
    for (int i = 1; i < NI; i++) begin
      if (en[i]) begin
        r.o = r.o | o[i];
        s = s + $signed({{2{d[i][W-1]}}, d[i]});
        case (op)
          3'd2: if ($signed(d[i]) > $signed(r.d)) r.d = d[i];
          3'd3: r.d = r.d & d[i];
          3'd4: r.d = r.d | d[i];
          3'd5: r.d = r.d ^ d[i];
          default: ;
        endcase
      end
    end
    if (op == 3'd1) begin
      r.d = s[W-1:0];
      if (s != $signed({{2{s[W-1]}}, s[W-1:0]})) r.o = 1'b1;
    end
    return r;
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    if (op == 3'd1) return "R3";
    if (op >= 3'd2 && op <= 3'd5) return "R1";
    return "R4";
  endfunction

  // cycle model: compare at the falling edge, advance to the next rising edge
  always @(negedge clk) begin
    if (!rstN) begin
      mUpV = 1'b0; mDnPend = '0; upQ.delete(); hsVec = '0; dnInHs = 1'b0;
    end else begin
      logic [NI-1:0] en, iv, rdy, dr, expRdy, hs, pick;
      logic comb, dnSpace, upSink, upSpace, allV, srcV;
      item_t nw, front;
      en   = {childEn, 1'b1};
      iv   = tbValid;
      rdy  = {childReady, localReady};
      dr   = {dnChildReady, dnLocalReady};
      comb = (opCode >= 3'd1) && (opCode <= 3'd5);
      dnSpace = ((mDnPend & ~dr) == '0);
      upSink  = isRoot ? dnSpace : upReady;
      upSpace = !mUpV || upSink;
      allV    = ((iv | ~en) == '1);
      pick = '0;
      for (int i = NI - 1; i >= 0; i--) if (iv[i] && en[i]) begin pick = '0; pick[i] = 1'b1; end
      if (comb) expRdy = (allV && upSpace) ? en : '0;
      else      expRdy = upSpace ? pick : '0;

      chk(rdy == expRdy, comb ? "R2" : "R4", "input ready", W'(rdy), W'(expRdy));
      chk((rdy & ~en) == '0, "R5", "ready on absent child", W'(rdy), W'(rdy & en));
      chk(upValid == (mUpV && !isRoot), isRoot ? "R7" : "R6", "upValid",
          W'(upValid), W'(mUpV && !isRoot));
      chk(dnInReady == (!isRoot && dnSpace), isRoot ? "R7" : "R8", "dnInReady",
          W'(dnInReady), W'(!isRoot && dnSpace));
      chk({dnChildValid, dnLocalValid} == mDnPend, "R8", "downward valids",
          W'({dnChildValid, dnLocalValid}), W'(mDnPend));
      if (upValid && mUpV && upQ.size() > 0) begin
        chk(upData == upQ[0].d && upOvf == upQ[0].o, tagOf(upQ[0].op), "up word",
            {upOvf, upData}, {upQ[0].o, upQ[0].d});
        if (upOvf && upQ[0].o && upQ[0].op == 3'd1) ovfSeen++;
        if (upQ[0].op == 3'd0 || upQ[0].op > 3'd5) bcastSeen++;
      end
      if (mDnPend != '0) begin
        chk(dnData == mDn.d && dnOvf == mDn.o, "R8", "down word",
            {dnOvf, dnData}, {mDn.o, mDn.d});
      end

      hs = expRdy & iv;
      if (comb) nw = refComb(opCode, en, tbData, tbOvf);
      else begin
        nw.d = '0; nw.o = 1'b0; nw.op = opCode;
        for (int i = 0; i < NI; i++) if (pick[i]) begin nw.d = tbData[i]; nw.o = tbOvf[i]; end
      end
      srcV = isRoot ? mUpV : dnInValid;
      if (srcV && dnSpace) begin
        if (isRoot) begin
          front = upQ[0]; mDn = front;
        end else begin
          mDn.d = dnInData; mDn.o = dnInOvf; mDn.op = 3'd0;
        end
        mDnPend = en;
      end else begin
        mDnPend = mDnPend & ~dr;
      end
      if (mUpV && upSink && upQ.size() > 0) front = upQ.pop_front();
      if (hs != '0) begin
        upQ.push_back(nw); mUpV = 1'b1;
      end else if (upSink) begin
        mUpV = 1'b0;
      end
      hsVec  = hs;
      dnInHs = !isRoot && dnInValid && dnSpace;
    end
  end

  function automatic logic [W-1:0] pickVal();
    case ($urandom % 6)
      0: return {1'b0, {(W-1){1'b1}}};
      1: return {1'b1, {(W-1){1'b0}}};
      2: return '1;
      3: return '0;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic stepDrive(input int pV, input bit stallUp, input int pDn);
    @(posedge clk); #2;
    for (int i = 0; i < NI; i++) begin
      if (!tbValid[i] || hsVec[i]) begin
        tbValid[i] = ($urandom % 100) < pV;
        tbData[i]  = pickVal();
        tbOvf[i]   = (i != 0) && (($urandom % 16) == 0);
      end
    end
    upReady      = stallUp ? (($urandom % 4) != 0) : 1'b1;
    dnLocalReady = ($urandom % 3) != 0;
    dnChildReady = NC'($urandom);
    if (!dnInValid || dnInHs) begin
      dnInValid = ($urandom % 100) < pDn;
      dnInData  = {$urandom, $urandom};
      dnInOvf   = ($urandom % 8) == 0;
    end
  endtask

  task automatic run(input int n, input int pV, input int pDn);
    for (int k = 0; k < n; k++) stepDrive(pV, 1'b1, pDn);
  endtask

  task automatic drain();
    @(posedge clk); #2;
    tbValid = '0; dnInValid = 1'b0;
    upReady = 1'b1; dnLocalReady = 1'b1; dnChildReady = '1;
    repeat (12) @(posedge clk);
  endtask

  task automatic setCfg(input logic root, input logic [NC-1:0] en, input logic [2:0] op);
    @(posedge clk); #2;
    isRoot = root; childEn = en; opCode = op;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired before the scenario list finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; opCode = 3'd1; isRoot = 1'b0; childEn = '1;
    tbValid = '0; tbData = '0; tbOvf = '0; upReady = 1'b1;
    dnInValid = 1'b0; dnInData = '0; dnInOvf = 1'b0;
    dnLocalReady = 1'b1; dnChildReady = '1;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R9: idle after reset
    chk(!upValid && !dnLocalValid && dnChildValid == '0, "R9", "valids after reset",
        W'({upValid, dnLocalValid, dnChildValid}), '0);

    // R3 sums with overflow, R8 downward traffic alongside
    setCfg(1'b0, 2'b11, 3'd1); run(1500, 70, 50); drain();
    // R1 maximum with child 1 absent (R5)
    setCfg(1'b0, 2'b01, 3'd2); run(800, 70, 50); drain();
    setCfg(1'b0, 2'b10, 3'd3); run(600, 70, 50); drain();
    setCfg(1'b0, 2'b00, 3'd4); run(600, 70, 50); drain();
    setCfg(1'b0, 2'b11, 3'd5); run(600, 70, 50); drain();
    // R4 broadcast priority, both codes
    setCfg(1'b0, 2'b11, 3'd0); run(800, 60, 50); drain();
    setCfg(1'b0, 2'b10, 3'd6); run(300, 60, 50); drain();
    // R7 root turnaround
    setCfg(1'b1, 2'b11, 3'd1); run(800, 70, 50); drain();
    setCfg(1'b1, 2'b01, 3'd5); run(400, 70, 50); drain();
    setCfg(1'b1, 2'b11, 3'd7); run(400, 60, 50); drain();

    @(negedge clk);
    chk(upQ.size() == 0 && mDnPend == '0, "R6", "all results delivered",
        W'(upQ.size()), '0);
    chk(ovfSeen > 0, "R3", "sum overflow observed", W'(ovfSeen), W'(1));
    chk(bcastSeen > 0, "R4", "broadcast words observed", W'(bcastSeen), W'(1));
    finishRun();
  end

endmodule